// File: doc/BRIEF.md
# DMA Channel Event Status and Interrupt Combiner

This block keeps the event status of every channel in a multi-channel DMA controller and merges them into one shared interrupt. Each channel owns an 8-bit status lane. Five kinds of event from the channel engine set sticky flags: transfer error, programming error, segment done, list done and chain done. A sixth sticky flag, null done, is set by a programming-error pulse that arrives while the remaining byte count is zero. Such an interrupt-only descriptor is not treated as a fault. Software clears sticky flags by writing ones to them. Writing back a value that was just read therefore clears everything that read showed as set.

Two further bits in each lane mirror the live busy and halted inputs. They never raise an interrupt. From them the block derives an idle signal for the channel's control logic: the channel is idle when it is not busy, or when it is halted. Each sticky flag is masked by its own enable bit. A channel interrupts when any enabled flag is set, and the global interrupt is the OR of the channel interrupts. A global status word places the masked flags of each channel in one byte, with channel 0 in the top byte. The block also gives the channel number that the lowest set bit of that word points to.

Top module: `dma_evt_agg`

## Requirements
- R1: After reset every sticky flag is clear, every interrupt is low and the global status word is zero.
- R2: A one-cycle pulse on an event input sets that channel's flag, readable on the next cycle. The lane bits are: bit 0 transfer error, bit 1 programming error, bit 2 segment done, bit 3 list done, bit 4 chain done.
- R3: A programming-error pulse with the channel's zero-count input high sets bit 5 (null done) and leaves bit 1 clear. With zero-count low, the same pulse sets bit 1 only.
- R4: A write to a channel clears the sticky flags at the positions where the written data has ones and leaves the others unchanged. Writing back the value just read clears every flag that was set.
- R5: If a clearing write and a new event hit the same flag in the same cycle, the flag stays set.
- R6: Lane bit 7 reads the live busy input and bit 6 reads the live halted input. Writes to these bits have no effect, and the bits never raise an interrupt.
- R7: A channel's idle output is high exactly when its busy input is low or its halted input is high.
- R8: A channel interrupt is high when any sticky flag with its enable bit set is high. Each channel has six enables, and enable bit k gates lane bit k. The global interrupt is the OR of all channel interrupts.
- R9: The global status word holds each channel's enabled sticky flags in one byte. Channel c occupies bits [8*(N-c)-1 : 8*(N-c)-8], so channel 0 is in the most significant byte. Bits 7:6 of every lane are zero.
- R10: When any channel is pending, the channel-select output equals (32 - p) / 8, where p is the 1-based position of the lowest set bit of the global word. This is the highest-numbered pending channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_xfer_err | input | NCH | Transfer-error event pulse per channel |
| ev_prog_err | input | NCH | Programming-error event pulse per channel |
| ev_seg_end | input | NCH | Segment-done event pulse per channel |
| ev_list_end | input | NCH | List-done event pulse per channel |
| ev_chain_end | input | NCH | Chain-done event pulse per channel |
| cnt_zero | input | NCH | Remaining byte count of the channel is zero |
| busy_in | input | NCH | Live busy state per channel |
| halt_in | input | NCH | Live halted state per channel |
| ien | input | 6*NCH | Per-flag interrupt enables, 6 per channel |
| wr_en | input | 1 | Write-one-to-clear strobe |
| wr_ch | input | CW | Channel addressed by the write |
| wr_data | input | 8 | Write data, ones clear flags |
| rd_ch | input | CW | Channel whose lane appears on rd_data |
| rd_data | output | 8 | Status lane of the selected channel |
| chan_irq | output | NCH | Per-channel interrupt |
| glob_irq | output | 1 | Combined interrupt |
| chan_idle | output | NCH | Per-channel idle indication |
| glob_stat | output | 8*NCH | Global status word |
| irq_chan | output | CW | Channel selected from the lowest set bit of the global word |
| irq_any | output | 1 | Some channel is pending |

## Verification
The event inputs are applied one kind at a time to a single channel. This separates the lane positions from each other and tells the null-done path apart from a real programming error. Partial, zero and read-back clearing writes show that clears act bit by bit. A write that collides with an event on the same bit shows which of the two has priority. The live inputs are toggled on their own to prove they reach neither the sticky flags nor any interrupt. Narrow enable masks and pending flags on two channels at once show the gating, the byte order of the global word and the channel-select formula.

// File: rtl/dma_evt_agg.sv
module dma_evt_agg #(
  parameter int NCH  = 4,
  parameter int LANE = 8,
  localparam int EVW = 6,
  localparam int CW  = $clog2(NCH),
  localparam int GW  = NCH * LANE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    ev_xfer_err,
  input  logic [NCH-1:0]    ev_prog_err,
  input  logic [NCH-1:0]    ev_seg_end,
  input  logic [NCH-1:0]    ev_list_end,
  input  logic [NCH-1:0]    ev_chain_end,
  input  logic [NCH-1:0]    cnt_zero,
  input  logic [NCH-1:0]    busy_in,
  input  logic [NCH-1:0]    halt_in,
  input  logic [EVW*NCH-1:0] ien,
  input  logic              wr_en,
  input  logic [CW-1:0]     wr_ch,
  input  logic [LANE-1:0]   wr_data,
  input  logic [CW-1:0]     rd_ch,
  output logic [LANE-1:0]   rd_data,
  output logic [NCH-1:0]    chan_irq,
  output logic              glob_irq,
  output logic [NCH-1:0]    chan_idle,
  output logic [GW-1:0]     glob_stat,
  output logic [CW-1:0]     irq_chan,
  output logic              irq_any
);

  logic [LANE-1:0] lane_q [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [EVW-1:0] sticky_q, set_v, clr_v, pend;

    assign set_v = {ev_prog_err[c] & cnt_zero[c], ev_chain_end[c], ev_list_end[c],
                    ev_seg_end[c], ev_prog_err[c] & ~cnt_zero[c], ev_xfer_err[c]};
    assign clr_v = (wr_en && wr_ch == CW'(c)) ? wr_data[EVW-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) sticky_q <= '0;
      else        sticky_q <= (sticky_q & ~clr_v) | set_v;

    assign pend         = sticky_q & ien[c*EVW +: EVW];
    assign chan_irq[c]  = |pend;
    assign chan_idle[c] = ~busy_in[c] | halt_in[c];
    assign lane_q[c]    = {busy_in[c], halt_in[c], sticky_q};
    assign glob_stat[GW-1-c*LANE -: LANE] = {{(LANE-EVW){1'b0}}, pend};
  end

  assign rd_data  = lane_q[rd_ch];
  assign glob_irq = |chan_irq;
  assign irq_any  = |chan_irq;

  always_comb begin
    irq_chan = '0;
    for (int c = 0; c < NCH; c++)
      if (chan_irq[c]) irq_chan = CW'(c);
  end

endmodule

module dma_evt_agg_chk #(
  parameter int NCH  = 4,
  parameter int LANE = 8,
  localparam int EVW = 6,
  localparam int CW  = $clog2(NCH),
  localparam int GW  = NCH * LANE
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCH-1:0]    ev_xfer_err,
  input logic [NCH-1:0]    ev_prog_err,
  input logic [NCH-1:0]    ev_seg_end,
  input logic [NCH-1:0]    ev_list_end,
  input logic [NCH-1:0]    ev_chain_end,
  input logic [NCH-1:0]    busy_in,
  input logic [NCH-1:0]    halt_in,
  input logic [EVW*NCH-1:0] ien,
  input logic              wr_en,
  input logic [CW-1:0]     wr_ch,
  input logic [LANE-1:0]   wr_data,
  input logic [NCH-1:0]    chan_irq,
  input logic              glob_irq,
  input logic [NCH-1:0]    chan_idle,
  input logic [GW-1:0]     glob_stat,
  input logic [CW-1:0]     irq_chan,
  input logic              irq_any
);

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    assert_busy_not_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_in[c] && !halt_in[c]) |-> !chan_idle[c]);
    assert_halt_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      halt_in[c] |-> chan_idle[c]);
    assert_event_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_xfer_err[c] && ien[c*EVW]) |=> chan_irq[c]);
    assert_full_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_ch == CW'(c) && wr_data[EVW-1:0] == '1 &&
       !ev_xfer_err[c] && !ev_prog_err[c] && !ev_seg_end[c] &&
       !ev_list_end[c] && !ev_chain_end[c]) |=> !chan_irq[c]);
    assert_lane_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
      chan_irq[c] == (glob_stat[GW-1-c*LANE -: LANE] != '0));
  end

  assert_glob_or_R8: assert property (@(posedge clk) disable iff (!rst_n)
    glob_irq == (glob_stat != '0));
  assert_sel_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_any |-> chan_irq[irq_chan]);

endmodule

bind dma_evt_agg dma_evt_agg_chk #(.NCH(NCH), .LANE(LANE)) u_chk (.*);

// File: tb/dma_evt_agg_test.sv
module dma_evt_agg_test;
  localparam int NCH = 4;
  localparam int CW  = 2;
  localparam int GW  = 32;

  logic clk = 0, rst_n = 0;
  logic [NCH-1:0] ev_te = 0, ev_pe = 0, ev_se = 0, ev_le = 0, ev_ce = 0;
  logic [NCH-1:0] cz = 0, busy = 0, halt = 0;
  logic [6*NCH-1:0] ien = '1;
  logic wr_en = 0;
  logic [CW-1:0] wr_ch = 0, rd_ch = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic [NCH-1:0] chan_irq, chan_idle;
  logic glob_irq, irq_any;
  logic [GW-1:0] glob_stat;
  logic [CW-1:0] irq_chan;

  int total = 0, bad = 0;

  always #2 clk = ~clk;

  dma_evt_agg #(.NCH(NCH)) uut (
    .clk(clk), .rst_n(rst_n), .ev_xfer_err(ev_te), .ev_prog_err(ev_pe),
    .ev_seg_end(ev_se), .ev_list_end(ev_le), .ev_chain_end(ev_ce),
    .cnt_zero(cz), .busy_in(busy), .halt_in(halt), .ien(ien),
    .wr_en(wr_en), .wr_ch(wr_ch), .wr_data(wr_data), .rd_ch(rd_ch),
    .rd_data(rd_data), .chan_irq(chan_irq), .glob_irq(glob_irq),
    .chan_idle(chan_idle), .glob_stat(glob_stat), .irq_chan(irq_chan),
    .irq_any(irq_any));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(int ch, output logic [7:0] v);
    rd_ch = CW'(ch);
    #0.5;
    v = rd_data;
  endtask

  // kind: 0 te, 1 pe, 2 seg, 3 list, 4 chain
  task automatic pulse(int ch, int kind, bit zero);
    @(negedge clk);
    cz[ch] = zero;
    case (kind)
      0: ev_te[ch] = 1;
      1: ev_pe[ch] = 1;
      2: ev_se[ch] = 1;
      3: ev_le[ch] = 1;
      default: ev_ce[ch] = 1;
    endcase
    @(negedge clk);
    ev_te = 0; ev_pe = 0; ev_se = 0; ev_le = 0; ev_ce = 0; cz = 0;
  endtask

  task automatic wr(int ch, logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_ch = CW'(ch); wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_data = 0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int c = 0; c < NCH; c++) begin
      rd(c, v);
      chk("R1 lane after reset", v, 0);
    end
    chk("R1 chan_irq", chan_irq, 0);
    chk("R1 glob_irq", glob_irq, 0);
    chk("R1 glob_stat", glob_stat, 0);
    chk("R7 idle at rest", chan_idle, 4'hF);
  endtask

  task automatic t_events();
    logic [7:0] v;
    for (int k = 0; k < 5; k++) begin
      pulse(1, k, 0);
      rd(1, v);
      chk("R2 event bit", v, 8'(1 << k));
      wr(1, v);
      rd(1, v);
      chk("R4 readback write clears", v, 0);
    end
    pulse(1, 1, 1);
    rd(1, v);
    chk("R3 null transfer sets bit5 only", v, 8'h20);
    wr(1, v);
  endtask

  task automatic t_w1c();
    logic [7:0] v;
    @(negedge clk);
    ev_te[2] = 1; ev_se[2] = 1;
    @(negedge clk);
    ev_te = 0; ev_se = 0;
    rd(2, v);
    chk("R2 two flags", v, 8'h05);
    wr(2, 8'h04);
    rd(2, v);
    chk("R4 partial clear", v, 8'h01);
    wr(2, 8'h00);
    rd(2, v);
    chk("R4 zero write keeps", v, 8'h01);
    wr(3, 8'hFF);
    rd(2, v);
    chk("R4 other channel write keeps", v, 8'h01);
    wr(2, v);
    rd(2, v);
    chk("R4 readback clears all", v, 0);
  endtask

  task automatic t_collide();
    logic [7:0] v;
    pulse(0, 1, 0);
    @(negedge clk);
    ev_te[0] = 1; wr_en = 1; wr_ch = 0; wr_data = 8'h03;
    @(negedge clk);
    ev_te = 0; wr_en = 0; wr_data = 0;
    rd(0, v);
    chk("R5 set wins, other bit cleared", v, 8'h01);
    wr(0, 8'h01);
  endtask

  task automatic t_live();
    logic [7:0] v;
    @(negedge clk);
    busy[3] = 1;
    rd(3, v);
    chk("R6 busy mirror", v, 8'h80);
    chk("R7 busy not idle", chan_idle[3], 0);
    chk("R6 busy no irq", chan_irq, 0);
    halt[3] = 1;
    rd(3, v);
    chk("R6 halt mirror", v, 8'hC0);
    chk("R7 halted idle", chan_idle[3], 1);
    wr(3, 8'hC0);
    rd(3, v);
    chk("R6 write ignored", v, 8'hC0);
    chk("R6 no glob irq", glob_irq, 0);
    busy = 0; halt = 0;
  endtask

  task automatic t_irq();
    ien = '1;
    ien[6 +: 6] = 6'b000100;
    pulse(1, 0, 0);
    chk("R8 masked flag no irq", chan_irq[1], 0);
    chk("R8 masked glob", glob_irq, 0);
    chk("R9 masked lane zero", glob_stat, 0);
    pulse(1, 2, 0);
    chk("R8 enabled flag irq", chan_irq[1], 1);
    chk("R8 glob irq", glob_irq, 1);
    wr(1, 8'h3F);
    chk("R8 cleared irq", glob_irq, 0);
    ien = '1;
  endtask

  task automatic t_glob();
    int pos, exp_ch;
    pulse(0, 0, 0);
    pulse(2, 4, 0);
    chk("R9 global word", glob_stat, 32'h0100_1000);
    pos = 0;
    for (int b = GW - 1; b >= 0; b--) if (glob_stat[b]) pos = b + 1;
    exp_ch = (32 - pos) / 8;
    chk("R10 lowest bit channel", irq_chan, 32'(exp_ch));
    chk("R10 irq_any", irq_any, 1);
    chk("R10 expected is ch2", 32'(exp_ch), 2);
    wr(2, 8'h10);
    chk("R10 after clear ch0", irq_chan, 0);
    pulse(3, 3, 0);
    chk("R9 ch3 low byte", glob_stat, 32'h0100_0008);
    chk("R10 ch3 selected", irq_chan, 3);
    wr(3, 8'h08);
    wr(0, 8'h01);
    chk("R1 idle again", glob_stat, 0);
  endtask

  initial begin
    #100000;
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_events();
    t_w1c();
    t_collide();
    t_live();
    t_irq();
    t_glob();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule